// File: doc/BRIEF.md
# Next-PC Unit for a Single-Cycle RISC Core

This block owns the program counter of a single-cycle 32-bit core. In every cycle it forms every candidate successor of the current PC: the sequential address, a PC-relative branch target, a register-indirect target and an absolute jump target. A two-bit select from the control decoder, together with the zero-test result for conditional branches, then picks one of them. The chosen value is shown on `next_pc_o` and is loaded into the PC at the next rising clock edge.

The sequential address (PC plus 4) is also brought out so the core can write it to the link register on jump-and-link instructions. Branch offsets and jump fields count in words. The branch reach is therefore plus or minus 128 KB around PC+4. An absolute jump stays inside the 256 MB region that holds PC+4.

Top module: `next_pc_unit`

## Requirements
- R1: A synchronous reset (`rst_i` high at a rising edge) loads the PC with the reset vector 0x00000000.
- R2: When `rst_i` is low at a rising edge, `pc_o` takes the value `next_pc_o` held just before that edge.
- R3: `pc_plus4_o` equals `pc_o` + 4 modulo 2^32, so 0xFFFFFFFC wraps to 0.
- R4: Select 2'b00 (sequential) gives `next_pc_o` = PC+4, whatever the values of `instr_i`, `rs_val_i` and `zero_i`.
- R5: Select 2'b01 with `zero_i` = 1 (branch taken) gives `next_pc_o` = PC+4 + (sign-extended `instr_i[15:0]` shifted left by 2).
- R6: Select 2'b01 with `zero_i` = 0 (branch not taken) gives `next_pc_o` = PC+4.
- R7: Select 2'b10 (register-indirect) gives `next_pc_o` = {`rs_val_i[31:2]`, 2'b00}, and `zero_i` has no effect.
- R8: Select 2'b11 (absolute) gives `next_pc_o` = {(PC+4)[31:28], `instr_i[25:0]`, 2'b00}, and neither `zero_i` nor `instr_i[31:26]` has any effect.
- R9: Bits [1:0] of `pc_o` are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; every state change happens on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value read from the rs register |
| zero_i | input | 1 | Zero-test result; 1 means the branch condition holds |
| sel_i | input | 2 | Next-PC select: 00 sequential, 01 branch, 10 indirect, 11 absolute |
| pc_o | output | 32 | Current program counter |
| pc_plus4_o | output | 32 | PC+4, also the link value |
| next_pc_o | output | 32 | PC value to be loaded at the next edge |

## Verification
`next_pc_o` and `pc_plus4_o` are combinational functions of the current PC and the inputs, so they settle in the same cycle as the stimulus. `pc_o` changes only one rising edge later. The bench drives each vector on the falling edge and checks the combinational outputs a quarter period later, before any edge. It then checks `pc_o` just after the following rising edge. The expected PC for each vector is the expected next PC of the vector before it, so a wrong register update carries into later checks.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [1:0] {
        NPC_SEQ = 2'b00,
        NPC_BR  = 2'b01,
        NPC_IND = 2'b10,
        NPC_ABS = 2'b11
    } npc_sel_e;

    localparam int NPC_XLEN  = 32;
    localparam int NPC_OFF_W = 16;
    localparam int NPC_JT_W  = 26;
    localparam int NPC_ALIGN = 2;

endpackage

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int JT_W  = 26,
    parameter int ALIGN = 2
) (
    input  logic [XLEN-1:0]       pc_i,
    input  logic [OFF_W-1:0]      off_i,
    input  logic [JT_W-1:0]       jt_i,
    input  logic [XLEN-ALIGN-1:0] rs_hi_i,
    output logic [XLEN-1:0]       pcp4_o,
    output logic [XLEN-1:0]       br_o,
    output logic [XLEN-1:0]       ind_o,
    output logic [XLEN-1:0]       abs_o
);
    localparam int             EXT_W = XLEN - OFF_W - ALIGN;
    localparam int             REG_W = XLEN - JT_W - ALIGN;
    localparam logic [XLEN-1:0] STEP = XLEN'(1) << ALIGN;

    logic [XLEN-1:0] off_ext;

    always_comb begin
        pcp4_o  = pc_i + STEP;
        off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i, {ALIGN{1'b0}}};
        br_o    = pcp4_o + off_ext;
        ind_o   = {rs_hi_i, {ALIGN{1'b0}}};
        abs_o   = {pcp4_o[XLEN-1 -: REG_W], jt_i, {ALIGN{1'b0}}};
    end

endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  npc_sel_e        sel_i,
    input  logic            taken_i,
    input  logic [XLEN-1:0] pcp4_i,
    input  logic [XLEN-1:0] br_i,
    input  logic [XLEN-1:0] ind_i,
    input  logic [XLEN-1:0] abs_i,
    output logic [XLEN-1:0] next_o
);
    always_comb begin
        unique case (sel_i)
            NPC_SEQ: next_o = pcp4_i;
            NPC_BR:  next_o = taken_i ? br_i : pcp4_i;
            NPC_IND: next_o = ind_i;
            NPC_ABS: next_o = abs_i;
            default: next_o = pcp4_i;
        endcase
    end

endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
    import npc_pkg::*;
#(
    parameter int              XLEN      = NPC_XLEN,
    parameter int              OFF_W     = NPC_OFF_W,
    parameter int              JT_W      = NPC_JT_W,
    parameter int              ALIGN     = NPC_ALIGN,
    parameter logic [XLEN-1:0] RESET_VEC = '0
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [XLEN-1:0] instr_i,
    input  logic [XLEN-1:0] rs_val_i,
    input  logic            zero_i,
    input  logic [1:0]      sel_i,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] pc_plus4_o,
    output logic [XLEN-1:0] next_pc_o
);
    localparam int REG_W = XLEN - JT_W - ALIGN;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } npc_state_t;

    npc_state_t      st_d, st_q;
    npc_sel_e        sel;
    logic [XLEN-1:0] pcp4, br_tgt, ind_tgt, abs_tgt, nxt;
    logic            unused_bits;

    assign sel         = npc_sel_e'(sel_i);
    assign unused_bits = ^{instr_i[XLEN-1:JT_W], rs_val_i[ALIGN-1:0]};

    npc_target_gen #(
        .XLEN (XLEN),
        .OFF_W(OFF_W),
        .JT_W (JT_W),
        .ALIGN(ALIGN)
    ) u_tgt (
        .pc_i   (st_q.pc),
        .off_i  (instr_i[OFF_W-1:0]),
        .jt_i   (instr_i[JT_W-1:0]),
        .rs_hi_i(rs_val_i[XLEN-1:ALIGN]),
        .pcp4_o (pcp4),
        .br_o   (br_tgt),
        .ind_o  (ind_tgt),
        .abs_o  (abs_tgt)
    );

    npc_select #(
        .XLEN(XLEN)
    ) u_sel (
        .sel_i  (sel),
        .taken_i(zero_i),
        .pcp4_i (pcp4),
        .br_i   (br_tgt),
        .ind_i  (ind_tgt),
        .abs_i  (abs_tgt),
        .next_o (nxt)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pc = nxt;
        if (rst_i) begin
            st_d.pc = RESET_VEC;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign pc_o       = st_q.pc;
    assign pc_plus4_o = pcp4;
    assign next_pc_o  = nxt;

    AST_RESET_VECTOR: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> pc_o == RESET_VEC); // R1

    AST_PC_LOADS_NEXT: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> pc_o == $past(next_pc_o)); // R2

    AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        sel == NPC_SEQ |-> next_pc_o == pc_plus4_o); // R4

    AST_BR_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel == NPC_BR && !zero_i) |-> next_pc_o == pc_plus4_o); // R6

    AST_ABS_REGION: assert property (@(posedge clk_i) disable iff (rst_i)
        sel == NPC_ABS |-> next_pc_o[XLEN-1 -: REG_W] == pc_plus4_o[XLEN-1 -: REG_W]); // R8

    AST_PC_ALIGNED: assert property (@(posedge clk_i) disable iff (rst_i)
        pc_o[ALIGN-1:0] == '0); // R9

endmodule

// File: tb/sim_next_pc_unit.sv
module sim_next_pc_unit;
    localparam int NV = 12;
    localparam int VW = 99;

    // {sel[1:0], zero, instr[31:0], rs[31:0], expected next pc[31:0]}
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'b00, 1'b1, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h0000_0004}, // R4 ignores other inputs
        {2'b01, 1'b1, 32'h1000_0010, 32'h0000_0000, 32'h0000_0048}, // R5 forward branch
        {2'b01, 1'b0, 32'h1000_0100, 32'hFFFF_FFFF, 32'h0000_004C}, // R6 not taken
        {2'b10, 1'b1, 32'h0000_0000, 32'h1234_5677, 32'h1234_5674}, // R7 low bits cleared
        {2'b11, 1'b1, 32'h0800_0100, 32'h0000_0000, 32'h1000_0400}, // R8 region
        {2'b01, 1'b1, 32'h1000_FFFF, 32'h0000_0000, 32'h1000_0400}, // R5 offset -1
        {2'b01, 1'b1, 32'h1000_8000, 32'h0000_0000, 32'h0FFE_0404}, // R5 most negative
        {2'b01, 1'b1, 32'h1000_7FFF, 32'h0000_0000, 32'h1000_0404}, // R5 most positive
        {2'b10, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFC}, // R7
        {2'b00, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000}, // R3 wrap
        {2'b11, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0FFF_FFFC}, // R8 field all ones
        {2'b11, 1'b1, 32'h0C00_0000, 32'h0000_0000, 32'h1000_0000}  // R8 region of PC+4
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] instr, rs_val;
    logic        zero;
    logic [1:0]  sel;
    logic [31:0] pc, pcp4, npc;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] cur_pc;

    always #10 clk = ~clk;

    next_pc_unit u0 (
        .clk_i     (clk),
        .rst_i     (rst),
        .instr_i   (instr),
        .rs_val_i  (rs_val),
        .zero_i    (zero),
        .sel_i     (sel),
        .pc_o      (pc),
        .pc_plus4_o(pcp4),
        .next_pc_o (npc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL R2 watchdog expired actual hang expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; instr = '0; rs_val = '0; zero = 1'b0; sel = 2'b00;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset pc", pc, 32'h0000_0000);
        check("R9 reset alignment", {30'd0, pc[1:0]}, 32'd0);
        cur_pc = 32'h0;

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v      = VEC[i];
            sel    = v[98:97];
            zero   = v[96];
            instr  = v[95:64];
            rs_val = v[63:32];
            #5;
            check($sformatf("R3 pc+4 vec %0d", i), pcp4, cur_pc + 32'd4);
            check($sformatf("R4-R8 next pc vec %0d (sel %b)", i, sel), npc, v[31:0]);
            @(posedge clk);
            #1;
            check($sformatf("R2 pc load vec %0d", i), pc, v[31:0]);
            check($sformatf("R9 alignment vec %0d", i), {30'd0, pc[1:0]}, 32'd0);
            cur_pc = v[31:0];
            @(negedge clk);
        end

        // R1: reset in mid-run overrides an absolute jump
        sel = 2'b11; instr = 32'h03FF_FFFF; zero = 1'b1; rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", pc, 32'h0000_0000);
        @(negedge clk);
        rst = 1'b0;

        // R7: zero_i has no effect on an indirect jump
        sel = 2'b10; rs_val = 32'h0000_0102; zero = 1'b0;
        #5;
        check("R7 zero low", npc, 32'h0000_0100);
        zero = 1'b1;
        #1;
        check("R7 zero high", npc, 32'h0000_0100);
        @(posedge clk);
        #1;
        check("R2 pc after indirect", pc, 32'h0000_0100);

        // R6 then R5 with the same offset: only zero_i decides
        @(negedge clk);
        sel = 2'b01; instr = 32'h0000_0003; zero = 1'b0;
        #5;
        check("R6 not taken", npc, 32'h0000_0104);
        zero = 1'b1;
        #1;
        check("R5 taken", npc, 32'h0000_0110);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule